// File: doc/BRIEF.md
# Variable-Length Instruction Dispatcher

This block walks a program held in a small internal memory of 32-bit words and hands out, one per clock cycle, a stream of instructions that are either one halfword (short) or two halfwords (long) in size. Instructions are packed back to back in the memory. The low half of each word comes before its high half, and a long instruction may begin in the high half of one word and end in the low half of the next.

Inside, a four-halfword buffer is built from two 32-bit instruction registers. Each register is split into a high half and a low half, and each half has its own enable and its own source multiplexer. A controller moves the halves after every dispatch, so that the head of the next instruction always sits in the low half of the second register. It starts a memory read only when the buffer can no longer hold the next instruction without one. A load port fills the memory while reset is held. After reset is released the block streams without pause and wraps around the program.

Top module: `vlen_dispatch`

## Requirements
- R1: A synchronous active-low reset clears the program counter, both instruction registers and the controller state. While reset is held, `instr_o` reads 0 and both valid strobes are low.
- R2: After reset is released, the first two cycles are spent on memory reads with no valid strobe. The first instruction is presented in the third cycle.
- R3: Bit 15 of an instruction's first halfword gives its length: 1 marks a long instruction and 0 marks a short one.
- R4: A short instruction is presented as `instr_o = {16'h0000, halfword}` with `short_vld_o` high for its single cycle.
- R5: A long instruction is presented with its first halfword in `instr_o[15:0]` and its second in `instr_o[31:16]`, with `long_vld_o` high for its single cycle.
- R6: Halfwords are consumed in ascending word address, low half (bits 15:0) before high half (bits 31:16). A long instruction may straddle two words.
- R7: Once started, exactly one instruction is dispatched every cycle, and the two valid strobes are never high together.
- R8: Each memory read advances the program counter by one. The counter wraps from 255 to 0, so the stream continues with word 0.
- R9: A short instruction dispatched while the buffer holds four halfwords starts no memory read. Every other dispatch starts one.
- R10: While `load_en` is high, `load_data` is written to word `load_addr`. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Program memory write strobe |
| load_addr | input | 8 | Program memory write address |
| load_data | input | 32 | Program memory write data |
| instr_o | output | 32 | Aligned instruction; upper half zero for a short one |
| short_vld_o | output | 1 | A short instruction is on `instr_o` |
| long_vld_o | output | 1 | A long instruction is on `instr_o` |

## Verification
The assertions on counter steps and state sequences assume the program memory stays unchanged while the block is running. The stimulus therefore writes memory only while reset is held, and then lets the stream run untouched. Programs come from a fixed-seed generator with a random mix of length bits, plus directed all-short and all-long images. Runs are long enough to wrap the program counter, and one reset in mid-stream checks that the stream restarts at word 0 from the retained memory.

// File: rtl/vlen_dispatch_pkg.sv
// Shared types for the variable-length dispatcher.
// Assumes: four halfword slots, filled from five possible sources.
package vlen_dispatch_pkg;

    // Controller states; the name gives how many buffer halves hold valid data.
    typedef enum logic [1:0] {
        ST_BOOT0 = 2'd0,
        ST_BOOT1 = 2'd1,
        ST_FULL4 = 2'd2,
        ST_HAVE3 = 2'd3
    } disp_state_e;

    // Slot indices: 0 = IR1 low (head), 1 = IR1 high, 2 = IR0 low, 3 = IR0 high.
    localparam int SLOT_N   = 4;
    localparam int SLOT_I1L = 0;
    localparam int SLOT_I1H = 1;
    localparam int SLOT_I0L = 2;
    localparam int SLOT_I0H = 3;

    // Source codes shared by every half multiplexer.
    localparam int SRC_N  = 5;
    localparam int SRC_W  = $clog2(SRC_N);
    localparam logic [SRC_W-1:0] SRC_I1H = 3'd0;
    localparam logic [SRC_W-1:0] SRC_I0L = 3'd1;
    localparam logic [SRC_W-1:0] SRC_I0H = 3'd2;
    localparam logic [SRC_W-1:0] SRC_MLO = 3'd3;
    localparam logic [SRC_W-1:0] SRC_MHI = 3'd4;

endpackage

// File: rtl/vlen_dispatch_pm.sv
// Program memory with load port and program counter.
// The read is combinational from the counter. The counter steps on each read.
// Assumes: writes happen only while the dispatcher is held in reset.
module vlen_dispatch_pm #(
    parameter int HALF_W   = 16,
    parameter int PM_DEPTH = 256,
    localparam int WORD_W  = 2 * HALF_W,
    localparam int PM_AW   = $clog2(PM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr_en,
    input  logic [PM_AW-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [PM_DEPTH];
    logic [PM_AW-1:0]  pc;

    // Memory write from the load port; contents are not reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Program counter: clears on reset, advances once per read, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (rd) begin
            pc <= pc + 1'b1;
        end
    end

    assign rd_data = mem[pc];

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd) |=> (pc == $past(pc) + 1'b1)); // R8
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rd) |=> $stable(pc)); // R9

endmodule

// File: rtl/vlen_dispatch_half.sv
// One 16-bit instruction register half with its own source mux and enable.
// Assumes: the select is one of the SRC_N codes; other codes keep the value.
module vlen_dispatch_half
    import vlen_dispatch_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic [SRC_W-1:0]             sel,
    input  logic [SRC_N-1:0][HALF_W-1:0] src,
    output logic [HALF_W-1:0]            q
);

    logic [HALF_W-1:0] d;

    // Source multiplexer for this half.
    always_comb begin
        d = q;
        if (int'(sel) < SRC_N) begin
            d = src[sel];
        end
    end

    // Half register: sync clear, load on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/vlen_dispatch_ctrl.sv
// Controller: tracks buffer occupancy, picks mux sources and enables,
// issues memory reads and raises the dispatch strobes.
// Assumes: head_long reflects the length bit of the halfword in IR1 low.
module vlen_dispatch_ctrl
    import vlen_dispatch_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         head_long,
    output logic [SLOT_N-1:0][SRC_W-1:0] sel,
    output logic [SLOT_N-1:0]            en,
    output logic                         rd,
    output logic                         short_vld,
    output logic                         long_vld
);

    disp_state_e state, nxt;

    // State register with sync clear to the first fetch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT0;
        end else begin
            state <= nxt;
        end
    end

    // Next state, mux selects, enables and read request.
    always_comb begin
        nxt = state;
        sel = '0;
        en  = '0;
        rd  = 1'b0;
        unique case (state)
            ST_BOOT0: begin
                sel[SLOT_I0L] = SRC_MLO; en[SLOT_I0L] = 1'b1;
                sel[SLOT_I0H] = SRC_MHI; en[SLOT_I0H] = 1'b1;
                rd  = 1'b1;
                nxt = ST_BOOT1;
            end
            ST_BOOT1: begin
                sel = {SRC_MHI, SRC_MLO, SRC_I0H, SRC_I0L};
                en  = '1;
                rd  = 1'b1;
                nxt = ST_FULL4;
            end
            ST_FULL4: begin
                if (head_long) begin
                    sel = {SRC_MHI, SRC_MLO, SRC_I0H, SRC_I0L};
                    en  = '1;
                    rd  = 1'b1;
                end else begin
                    sel[SLOT_I1L] = SRC_I1H; en[SLOT_I1L] = 1'b1;
                    sel[SLOT_I1H] = SRC_I0L; en[SLOT_I1H] = 1'b1;
                    sel[SLOT_I0L] = SRC_I0H; en[SLOT_I0L] = 1'b1;
                    nxt = ST_HAVE3;
                end
            end
            ST_HAVE3: begin
                rd = 1'b1;
                if (head_long) begin
                    sel[SLOT_I1L] = SRC_I0L; en[SLOT_I1L] = 1'b1;
                    sel[SLOT_I1H] = SRC_MLO; en[SLOT_I1H] = 1'b1;
                    sel[SLOT_I0L] = SRC_MHI; en[SLOT_I0L] = 1'b1;
                end else begin
                    sel = {SRC_MHI, SRC_MLO, SRC_I0L, SRC_I1H};
                    en  = '1;
                    nxt = ST_FULL4;
                end
            end
            default: nxt = ST_BOOT0;
        endcase
    end

    // Dispatch strobes: one instruction per cycle once the buffer is primed.
    always_comb begin
        short_vld = (state == ST_FULL4 || state == ST_HAVE3) && !head_long;
        long_vld  = (state == ST_FULL4 || state == ST_HAVE3) &&  head_long;
    end

    AST_ONE_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({short_vld, long_vld})); // R7
    AST_BOOT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state == ST_BOOT0) |=> (state == ST_BOOT1)); // R2
    AST_SHORT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state == ST_FULL4 && !head_long) |=> (state == ST_HAVE3)); // R9
    AST_KEEP_GOING: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (short_vld || long_vld)) |=> (short_vld || long_vld)); // R7

endmodule

// File: rtl/vlen_dispatch.sv
// Top level: program memory, four half registers and the controller.
// The head instruction always starts in IR1 low; instr_o carries it aligned.
// Assumes: memory is loaded only while rst_n is low.
module vlen_dispatch
    import vlen_dispatch_pkg::*;
#(
    parameter int HALF_W   = 16,
    parameter int PM_DEPTH = 256,
    localparam int WORD_W  = 2 * HALF_W,
    localparam int PM_AW   = $clog2(PM_DEPTH),
    localparam int LEN_BIT = HALF_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [PM_AW-1:0]  load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] instr_o,
    output logic              short_vld_o,
    output logic              long_vld_o
);

    logic [WORD_W-1:0]            mem_word;
    logic                         rd;
    logic [SLOT_N-1:0][SRC_W-1:0] sel;
    logic [SLOT_N-1:0]            en;
    logic [SLOT_N-1:0][HALF_W-1:0] slot;
    logic [SRC_N-1:0][HALF_W-1:0]  src;
    logic                         short_vld, long_vld;

    vlen_dispatch_pm #(.HALF_W(HALF_W), .PM_DEPTH(PM_DEPTH)) u_pm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (rd),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_data (mem_word)
    );

    // Source bus shared by all half multiplexers.
    always_comb begin
        src          = '0;
        src[SRC_I1H] = slot[SLOT_I1H];
        src[SRC_I0L] = slot[SLOT_I0L];
        src[SRC_I0H] = slot[SLOT_I0H];
        src[SRC_MLO] = mem_word[HALF_W-1:0];
        src[SRC_MHI] = mem_word[WORD_W-1:HALF_W];
    end

    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        vlen_dispatch_half #(.HALF_W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en[g]),
            .sel   (sel[g]),
            .src   (src),
            .q     (slot[g])
        );
    end

    vlen_dispatch_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_long (slot[SLOT_I1L][LEN_BIT]),
        .sel       (sel),
        .en        (en),
        .rd        (rd),
        .short_vld (short_vld),
        .long_vld  (long_vld)
    );

    // Output word: upper half only for long instructions.
    always_comb begin
        instr_o     = {(long_vld ? slot[SLOT_I1H] : {HALF_W{1'b0}}), slot[SLOT_I1L]};
        short_vld_o = short_vld;
        long_vld_o  = long_vld;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(short_vld_o || long_vld_o)); // R1

endmodule

// File: tb/vlen_dispatch_tb.sv
module vlen_dispatch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int WDOG_LIM   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] instr_o;
    logic        short_vld_o, long_vld_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [31:0] prog [DEPTH];
    int hpos;

    vlen_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .instr_o(instr_o),
        .short_vld_o(short_vld_o), .long_vld_o(long_vld_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIM) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual %0d cycles expected < %0d", cycles, WDOG_LIM);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Halfword h of the program stream (low half first, wraps over memory).
    function automatic logic [15:0] hw(input int h);
        logic [31:0] w;
        w = prog[(h / 2) % DEPTH];
        return (h % 2 == 0) ? w[15:0] : w[31:16];
    endfunction

    // Hold reset, load the program image and check the quiet reset outputs.
    task automatic load_prog();
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = 8'(i); load_data = prog[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        check(instr_o == 32'h0 && !short_vld_o && !long_vld_o, "R1 reset outputs",
              {31'h0, short_vld_o, instr_o}, 64'h0);
    endtask

    // Release reset and compare the dispatched stream against the model.
    task automatic run_stream(input int n, input string tag);
        logic [15:0] h0;
        logic        exp_long;
        logic [31:0] exp_w;
        hpos = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!short_vld_o && !long_vld_o, "R2 no dispatch during fetch",
              {62'h0, short_vld_o, long_vld_o}, 64'h0);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            h0       = hw(hpos);
            exp_long = h0[15];
            exp_w    = exp_long ? {hw(hpos + 1), h0} : {16'h0, h0};
            if (c == 0) begin
                check(short_vld_o || long_vld_o, "R2 first dispatch in third cycle",
                      {62'h0, short_vld_o, long_vld_o}, 64'h1);
            end
            check((short_vld_o ^ long_vld_o) && (long_vld_o == exp_long) && (instr_o == exp_w),
                  {tag, " R3 R4 R5 R6 R7 R9 stream"},
                  {30'h0, long_vld_o, short_vld_o, instr_o}, {30'h0, exp_long, !exp_long, exp_w});
            hpos += exp_long ? 2 : 1;
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        // Random mixed program; long enough to wrap the counter (R8).
        for (int i = 0; i < DEPTH; i++) prog[i] = $urandom();
        load_prog();
        run_stream(700, "R8 random");
        check(hpos > 2 * DEPTH, "R8 counter wrapped", 64'(hpos), 64'(2 * DEPTH));

        // Reset mid-stream: quiet outputs, stream restarts from word 0 (R10 retention).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(instr_o == 32'h0 && !short_vld_o && !long_vld_o, "R1 mid-run reset",
              {31'h0, long_vld_o, instr_o}, 64'h0);
        run_stream(60, "R10 retained");

        // All short: bit 15 clear in both halves.
        for (int i = 0; i < DEPTH; i++) prog[i] = $urandom() & 32'h7FFF_7FFF;
        load_prog();
        run_stream(600, "R4 all short");

        // All long, aligned to words.
        for (int i = 0; i < DEPTH; i++) prog[i] = $urandom() | 32'h0000_8000;
        load_prog();
        run_stream(300, "R5 all long");

        // Directed straddle: short then long split across words, repeating.
        for (int i = 0; i < DEPTH; i++)
            prog[i] = (i % 2 == 0) ? {16'h8000 | 16'(i), 16'h0100 | 16'(i)}
                                   : {16'h0200 | 16'(i), 16'h0300 | 16'(i)};
        load_prog();
        run_stream(200, "R6 straddle");

        finish_run();
    end

endmodule